// File: doc/BRIEF.md
# Power-Mode and Reset Sequencer

This controller turns three configuration bits into the power state of a converter core. The bits are power-down, deep-save select and a system-reset command. From them it produces the oscillator enable, the analog bias enable and the filter-run enable. Power-down on its own gives a light standby: the clock and the bias keep running, so the return is immediate. Power-down together with deep-save gives sleep, which also stops the oscillator. Leaving sleep therefore passes through a timed oscillator warm-up, which is skipped when an external clock is selected.

Writing the system-reset bit starts a counted internal reset pulse. The pulse clears the power bits, and writes to the power bits are ignored while it runs. When the pulse ends, a reset-valid flag is raised. A read of the configuration register clears that flag. The warm-up length and the reset pulse length are parameters. The warm-up default matches 20 ms at 50 MHz.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After the asynchronous reset the block is in normal mode (mode 0), with osc_en, bias_en and filt_run high and busy, core_rst and rst_valid low.
- R2: mode encodes 0 normal, 1 standby, 2 sleep, 3 warm-up wait. osc_en and bias_en are high in every mode but sleep. filt_run is high only in normal. busy is high only in the warm-up wait.
- R3: A write with cfg_pdn=1 and cfg_deep=0 reaches standby. The mode appears in the second cycle after the write strobe: one register for the configuration and one for the state.
- R4: A write with cfg_pdn=1 and cfg_deep=1 reaches sleep with the same latency.
- R5: From standby, clearing cfg_pdn returns to normal with the same two-cycle latency and no wait.
- R6: With ext_clk=0, leaving sleep for normal or standby passes through exactly WAKE_CYC cycles of warm-up wait, then enters the mode the configuration selects.
- R7: With ext_clk=1, leaving sleep, or being in the wait, moves straight to the selected mode on the next clock, and busy never rises.
- R8: A write with cfg_sysrst=1 drives core_rst high for RST_CYC cycles, starting in the cycle after the write. It clears both power bits, and the power bits carried by that same write are ignored.
- R9: Writes with cfg_sysrst=0 that arrive while core_rst is high leave the power bits, and so the mode, unchanged.
- R10: rst_valid rises in the cycle in which core_rst falls. A write with cfg_sysrst=1 clears it. Otherwise a cfg_re strobe clears it. If completion and cfg_re coincide, the flag is set.
- R11: If, during the warm-up wait, the configuration selects sleep again, the block returns to sleep on the next state update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pdn | input | 1 | Written power-down bit |
| cfg_deep | input | 1 | Written deep-save select bit |
| cfg_sysrst | input | 1 | Written system-reset command bit |
| cfg_re | input | 1 | Configuration read strobe, clears rst_valid |
| ext_clk | input | 1 | External clock selected, skips the warm-up |
| mode | output | 2 | Current power mode (R2 encoding) |
| osc_en | output | 1 | Oscillator enable |
| bias_en | output | 1 | Analog bias enable |
| filt_run | output | 1 | Filter-run enable |
| busy | output | 1 | Oscillator warm-up in progress |
| core_rst | output | 1 | Internal logic reset pulse |
| rst_valid | output | 1 | Reset completed status |

## Verification
Two events can fall on the same clock edge: the end of the reset pulse, which sets rst_valid, and a configuration read, which clears it. The bench places cfg_re exactly on the edge where core_rst drops. It expects rst_valid to stay high in that cycle and the next, and to go low only after a later read. A second pairing is a power-bit write landing inside the reset pulse. The bench judges it by the mode, which must stay normal after the pulse ends.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DARK = 2'd2,
    PM_WARM = 2'd3
  } pm_state_e;

  typedef struct packed {
    logic pdn;
    logic deep;
  } pm_cfg_t;

  function automatic pm_state_e pm_target(input pm_cfg_t c);
    if (!c.pdn)      return PM_RUN;
    else if (c.deep) return PM_DARK;
    else             return PM_IDLE;
  endfunction

endpackage

// File: rtl/pwr_cfg_reg.sv
`timescale 1ns/1ps
module pwr_cfg_reg
  import pwr_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_en,
  input  logic    wr_pdn,
  input  logic    wr_deep,
  input  logic    wr_sysrst,
  input  logic    hold,
  output pm_cfg_t cfg_q
);

  pm_cfg_t cfg_d;
  logic    cfg_ce;

  always_comb begin
    cfg_ce = 1'b0;
    cfg_d  = cfg_q;
    if (wr_en && wr_sysrst) begin
      cfg_ce = 1'b1;
      cfg_d  = '0;
    end else if (wr_en && !hold) begin
      cfg_ce    = 1'b1;
      cfg_d.pdn  = wr_pdn;
      cfg_d.deep = wr_deep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_ce) cfg_q <= cfg_d;
  end

endmodule

// File: rtl/pwr_sysrst_ctrl.sv
`timescale 1ns/1ps
module pwr_sysrst_ctrl #(
  parameter int RST_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rd_clr,
  output logic pulse,
  output logic valid
);

  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_CYC);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;
  logic          valid_d, valid_ce;
  logic          done;

  assign pulse = (cnt_q != '0);
  assign done  = (cnt_q == ONE) && !start;

  always_comb begin
    cnt_ce = 1'b0;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_ce = 1'b1;
      cnt_d  = LOAD;
    end else if (pulse) begin
      cnt_ce = 1'b1;
      cnt_d  = cnt_q - ONE;
    end
  end

  always_comb begin
    valid_ce = 1'b1;
    if (start)       valid_d = 1'b0;
    else if (done)   valid_d = 1'b1;
    else if (rd_clr) valid_d = 1'b0;
    else begin
      valid_ce = 1'b0;
      valid_d  = valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        valid <= 1'b0;
    else if (valid_ce) valid <= valid_d;
  end

endmodule

// File: rtl/pwr_mode_fsm.sv
`timescale 1ns/1ps
module pwr_mode_fsm
  import pwr_seq_pkg::*;
#(
  parameter int WAKE_CYC = 1_000_000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  pm_cfg_t   cfg,
  input  logic      ext_clk,
  output pm_state_e state_q
);

  localparam int WW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
  localparam logic [WW-1:0] WLOAD = WW'(WAKE_CYC - 1);
  localparam logic [WW-1:0] WONE  = WW'(1);

  pm_state_e     state_d;
  pm_state_e     tgt;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          wcnt_ce;

  assign tgt = pm_target(cfg);

  always_comb begin
    state_d = state_q;
    wcnt_ce = 1'b0;
    wcnt_d  = wcnt_q;
    unique case (state_q)
      PM_RUN, PM_IDLE: state_d = tgt;
      PM_DARK: begin
        if (tgt != PM_DARK) begin
          if (ext_clk) state_d = tgt;
          else begin
            state_d = PM_WARM;
            wcnt_ce = 1'b1;
            wcnt_d  = WLOAD;
          end
        end
      end
      PM_WARM: begin
        if (tgt == PM_DARK)                    state_d = PM_DARK;
        else if (ext_clk || wcnt_q == '0)      state_d = tgt;
        else begin
          wcnt_ce = 1'b1;
          wcnt_d  = wcnt_q - WONE;
        end
      end
      default: state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_RUN;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wcnt_q <= '0;
    else if (wcnt_ce) wcnt_q <= wcnt_d;
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int WAKE_CYC = 1_000_000,
  parameter int RST_CYC  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_pdn,
  input  logic       cfg_deep,
  input  logic       cfg_sysrst,
  input  logic       cfg_re,
  input  logic       ext_clk,
  output logic [1:0] mode,
  output logic       osc_en,
  output logic       bias_en,
  output logic       filt_run,
  output logic       busy,
  output logic       core_rst,
  output logic       rst_valid
);

  pm_cfg_t   cfg_q;
  pm_state_e st;
  logic      rst_start;

  assign rst_start = cfg_we && cfg_sysrst;

  pwr_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_pdn    (cfg_pdn),
    .wr_deep   (cfg_deep),
    .wr_sysrst (cfg_sysrst),
    .hold      (core_rst),
    .cfg_q     (cfg_q)
  );

  pwr_sysrst_ctrl #(.RST_CYC(RST_CYC)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (rst_start),
    .rd_clr (cfg_re),
    .pulse  (core_rst),
    .valid  (rst_valid)
  );

  pwr_mode_fsm #(.WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (cfg_q),
    .ext_clk (ext_clk),
    .state_q (st)
  );

  assign mode     = st;
  assign osc_en   = (st != PM_DARK);
  assign bias_en  = (st != PM_DARK);
  assign filt_run = (st == PM_RUN);
  assign busy     = (st == PM_WARM);

endmodule

// File: rtl/pwr_seq_chk.sv
`timescale 1ns/1ps
module pwr_seq_chk #(
  parameter int WAKE_CYC = 1_000_000,
  parameter int RST_CYC  = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       cfg_sysrst,
  input logic       cfg_re,
  input logic       ext_clk,
  input logic [1:0] mode,
  input logic       osc_en,
  input logic       bias_en,
  input logic       filt_run,
  input logic       busy,
  input logic       core_rst,
  input logic       rst_valid
);

  logic [31:0] busy_len;
  logic [31:0] rst_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 32'd1;
    else           busy_len <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rst_len <= '0;
    else if (cfg_we && cfg_sysrst)   rst_len <= '0;
    else if (core_rst)               rst_len <= rst_len + 32'd1;
    else                             rst_len <= '0;
  end

  a_r2_filter_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
    filt_run |-> (osc_en && bias_en));

  a_r6_wait_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(mode) == 2'd2));

  a_r6_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_len <= 32'(WAKE_CYC - 1)));

  a_r7_no_wait_on_ext: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !ext_clk);

  a_r8_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> (rst_len == 32'(RST_CYC)));

  a_r10_valid_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> rst_valid);

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_re && !core_rst) |=> !rst_valid);

endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.WAKE_CYC(WAKE_CYC), .RST_CYC(RST_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_sysrst (cfg_sysrst),
  .cfg_re     (cfg_re),
  .ext_clk    (ext_clk),
  .mode       (mode),
  .osc_en     (osc_en),
  .bias_en    (bias_en),
  .filt_run   (filt_run),
  .busy       (busy),
  .core_rst   (core_rst),
  .rst_valid  (rst_valid)
);

// File: tb/test_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module test_pwr_seq_ctrl;

  localparam int W   = 8;
  localparam int R   = 4;
  localparam time TCK = 20ns;

  localparam logic [1:0] M_RUN  = 2'd0;
  localparam logic [1:0] M_IDLE = 2'd1;
  localparam logic [1:0] M_DARK = 2'd2;
  localparam logic [1:0] M_WARM = 2'd3;

  logic       clk, rst_n;
  logic       cfg_we, cfg_pdn, cfg_deep, cfg_sysrst, cfg_re, ext_clk;
  logic [1:0] mode;
  logic       osc_en, bias_en, filt_run, busy, core_rst, rst_valid;

  pwr_seq_ctrl #(.WAKE_CYC(W), .RST_CYC(R)) i_pwr_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pdn(cfg_pdn),
    .cfg_deep(cfg_deep), .cfg_sysrst(cfg_sysrst), .cfg_re(cfg_re),
    .ext_clk(ext_clk), .mode(mode), .osc_en(osc_en), .bias_en(bias_en),
    .filt_run(filt_run), .busy(busy), .core_rst(core_rst),
    .rst_valid(rst_valid)
  );

  typedef struct {
    int         cyc;
    logic [1:0] m;
    logic       r;
    logic       v;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   finished = 0;

  initial begin
    clk = 1'b0;
    forever #(TCK/2) clk = ~clk;
  end

  // monitor: after each rising edge pop the items due in this cycle
  initial begin
    forever begin
      @(posedge clk);
      cyc = cyc + 1;
      #5ns;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].cyc == cyc) begin
          logic [6:0] act, expv;
          act  = {mode, osc_en, bias_en, filt_run, busy, core_rst};
          expv = {q[i].m, q[i].m != M_DARK, q[i].m != M_DARK,
                  q[i].m == M_RUN, q[i].m == M_WARM, q[i].r};
          n_tests++;
          if (act !== expv || rst_valid !== q[i].v) begin
            n_fail++;
            $display("FAIL %s: actual mode/osc/bias/filt/busy/rst=%b valid=%b expected %b valid=%b",
                     q[i].tag, act, rst_valid, expv, q[i].v);
          end
          q.delete(i);
        end
      end
    end
  end

  task automatic expect_at(input int ahead, input logic [1:0] m,
                           input logic r, input logic v, input string tag);
    exp_t e;
    e.cyc = cyc + ahead; e.m = m; e.r = r; e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic p, input logic d, input logic s);
    cfg_we = 1'b1; cfg_pdn = p; cfg_deep = d; cfg_sysrst = s;
    @(negedge clk);
    cfg_we = 1'b0; cfg_pdn = 1'b0; cfg_deep = 1'b0; cfg_sysrst = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(TCK * 200000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_pdn = 1'b0; cfg_deep = 1'b0;
    cfg_sysrst = 1'b0; cfg_re = 1'b0; ext_clk = 1'b0;
    tick(3);
    rst_n = 1'b1;
    expect_at(1, M_RUN, 1'b0, 1'b0, "R1 reset state");
    tick(2);

    // R3 standby
    expect_at(1, M_RUN,  1'b0, 1'b0, "R3 latency, still normal");
    expect_at(2, M_IDLE, 1'b0, 1'b0, "R3 standby");
    wr(1, 0, 0); tick(2);

    // R5 back to normal without wait
    expect_at(1, M_IDLE, 1'b0, 1'b0, "R5 still standby");
    expect_at(2, M_RUN,  1'b0, 1'b0, "R5 normal, no wait");
    wr(0, 0, 0); tick(2);

    // R4 sleep
    expect_at(2, M_DARK, 1'b0, 1'b0, "R4 sleep");
    wr(1, 1, 0); tick(2);

    // R6 timed warm-up back to normal
    expect_at(1,     M_DARK, 1'b0, 1'b0, "R6 held in sleep");
    expect_at(2,     M_WARM, 1'b0, 1'b0, "R6 wait starts");
    expect_at(1 + W, M_WARM, 1'b0, 1'b0, "R6 last wait cycle");
    expect_at(2 + W, M_RUN,  1'b0, 1'b0, "R6 normal after wait");
    wr(0, 0, 0); tick(W + 2);

    // R7 external clock skips the wait
    wr(1, 1, 0); tick(2);
    ext_clk = 1'b1;
    expect_at(2, M_RUN, 1'b0, 1'b0, "R7 direct to normal");
    wr(0, 0, 0); tick(2);
    ext_clk = 1'b0;

    // R6 sleep to standby also waits
    wr(1, 1, 0); tick(2);
    expect_at(2,     M_WARM, 1'b0, 1'b0, "R6 wait toward standby");
    expect_at(2 + W, M_IDLE, 1'b0, 1'b0, "R6 standby after wait");
    wr(1, 0, 0); tick(W + 2);

    // R11 wait aborted back to sleep
    wr(1, 1, 0); tick(2);
    wr(0, 0, 0); tick(2);
    expect_at(1, M_WARM, 1'b0, 1'b0, "R11 inside wait");
    expect_at(2, M_DARK, 1'b0, 1'b0, "R11 back to sleep");
    wr(1, 1, 0); tick(2);
    ext_clk = 1'b1;
    wr(0, 0, 0); tick(2);
    ext_clk = 1'b0;

    // R8 system reset from standby, power bits of the same write ignored
    wr(1, 0, 0); tick(2);
    expect_at(1,     M_IDLE, 1'b1, 1'b0, "R8 pulse starts");
    expect_at(2,     M_RUN,  1'b1, 1'b0, "R8 power bits cleared");
    expect_at(R,     M_RUN,  1'b1, 1'b0, "R8 pulse held");
    expect_at(R + 1, M_RUN,  1'b0, 1'b1, "R10 valid at pulse end");
    wr(1, 1, 1); tick(R + 1);

    // R9 power write during pulse ignored; R10 cleared by new reset
    expect_at(1,     M_RUN, 1'b1, 1'b0, "R10 cleared by new reset");
    expect_at(3,     M_RUN, 1'b1, 1'b0, "R9 write in pulse ignored");
    expect_at(R + 1, M_RUN, 1'b0, 1'b1, "R9 pulse end, valid");
    expect_at(R + 3, M_RUN, 1'b0, 1'b1, "R9 still normal after pulse");
    wr(0, 0, 1);
    wr(1, 1, 0);
    tick(R + 2);

    // R10 read clears
    expect_at(1, M_RUN, 1'b0, 1'b0, "R10 read clears");
    cfg_re = 1'b1; @(negedge clk); cfg_re = 1'b0;
    tick(1);

    // R10 read coinciding with completion
    expect_at(R + 1, M_RUN, 1'b0, 1'b1, "R10 set wins over read");
    expect_at(R + 2, M_RUN, 1'b0, 1'b1, "R10 stays set");
    expect_at(R + 3, M_RUN, 1'b0, 1'b0, "R10 later read clears");
    wr(0, 0, 1);
    tick(R - 1);
    cfg_re = 1'b1; @(negedge clk); cfg_re = 1'b0;
    tick(1);
    cfg_re = 1'b1; @(negedge clk); cfg_re = 1'b0;
    tick(3);

    if (q.size() != 0) begin
      n_tests++;
      n_fail++;
      $display("FAIL scoreboard (all requirements): actual=%0d pending expected=0", q.size());
    end
    finished = 1;
    summary();
    $finish;
  end

endmodule